// File: doc/BRIEF.md
# Transmit Interrupt Pending Controller

This block is the transmit side of a synchronous serial channel. The host writes data bytes into a small transmit FIFO. An output register, the byte-wide view of the shift register, takes bytes from the FIFO one at a time. When a frame's data runs out, the block appends a two-byte CRC, then a closing flag, and then sends idle flags until new data arrives. The block also produces the transmit interrupt pending flag and a buffer-empty status, and it tracks when each is raised and retired.

There are two pending levels. The first is the data level, raised when the FIFO reaches the threshold chosen by a mode pin. The second is the end-of-frame level, raised when the closing flag follows a CRC. The two levels are latched independently, so software can see both the last-data interrupt and the frame-end interrupt even when they overlap. A CRC that has started always completes. Bytes written during the CRC wait in the FIFO.

Back-pressure rules. On the host port a byte is accepted on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while the FIFO is full. A byte offered while `wr_ready` is low is dropped and not held, and the sticky overflow flag records the drop. On the output port `out_valid` is high on every cycle after reset. The sink takes `out_data` on a cycle where `out_ready` is high. While `out_ready` is low, the output register and the sequencing state do not change.

Top module: `txip_ctrl`

## Requirements
- R1: With `drain_mode`=1, the data level is raised by an output handshake that takes the last byte out of the FIFO. With `drain_mode`=0, it is raised by every output handshake that takes a byte from the FIFO.
- R2: No pending level is raised while `tx_ie` is low. Raising `tx_ie` when the FIFO is already empty does not set `txip`.
- R3: An accepted host byte retires one pending level, and so does a pulse on `ip_clear`. The data level is retired before the end-of-frame level. `txip` is the OR of the two levels.
- R4: Two conditions are needed for a CRC: `eom_clear` has been pulsed since the previous frame ended, and `crc_arm` has been pulsed. When both hold and the FIFO is empty at a handshake during a frame, the next three bytes are the CRC high byte, the CRC low byte and then flag 8'h7E. Loading that flag raises the end-of-frame level.
- R5: Once the CRC high byte is loaded, the next two handshakes deliver the CRC low byte and then the flag, even if host bytes are waiting in the FIFO. Those bytes follow afterwards, in order.
- R6: When both levels are set, one retire leaves `txip` high, and a second retire is needed to clear it.
- R7: Without `eom_clear` since the previous frame end, an empty FIFO during a frame yields flag 8'h7E. No CRC is sent and no end-of-frame level is raised.
- R8: `buf_empty` is high exactly when the FIFO holds no byte, whatever the value of `tx_ie`.
- R9: `wr_ready` is low while the FIFO holds DEPTH bytes (4 by default). A byte offered then is discarded and never sent, and it sets `overflow`. `overflow` stays high until reset.
- R10: After reset `txip`=0, `overflow`=0, `buf_empty`=1, `out_valid`=1 and `out_data`=8'h7E. Idle handshakes deliver 8'h7E.
- R11: The CRC is CRC-16 with polynomial 0x1021, processed MSB first and preset to 16'hFFFF at the frame's first byte, with no final inversion. It covers the frame's data bytes and is sent high byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_ie | input | 1 | Transmit interrupt enable |
| drain_mode | input | 1 | 1: interrupt when FIFO drains; 0: interrupt on every FIFO byte taken |
| wr_valid | input | 1 | Host byte offered |
| wr_ready | output | 1 | FIFO has room |
| wr_data | input | 8 | Host byte |
| ip_clear | input | 1 | Retire one pending level |
| crc_arm | input | 1 | Append CRC at the end of this frame |
| eom_clear | input | 1 | Reset the end-of-message latch |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes output byte |
| out_data | output | 8 | Byte in the shift register |
| txip | output | 1 | Transmit interrupt pending |
| buf_empty | output | 1 | FIFO empty status |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The hardest case to reach is a host write that lands while the CRC is in flight, with the last-data level still pending. The bench reaches it by holding `out_ready` low so the frame sits in the FIFO. It then advances the output one handshake at a time and inserts the new byte in the gap after the CRC high byte is loaded. From there it checks that the write retires only the data level, that the CRC low byte and the closing flag still come out ahead of the new byte, and that two retires are then needed.

// File: rtl/txip_pkg.sv
package txip_pkg;
  localparam int          BYTE_W   = 8;
  localparam logic [7:0]  IDLE_CHR = 8'h7E;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {
    SRC_NORM,
    SRC_CRC_LO,
    SRC_CLOSE
  } tx_src_e;

  function automatic logic [15:0] crc_step(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    logic        fb;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/txip_fifo.sv
module txip_fifo #(
  parameter  int DEPTH = 4,
  parameter  int W     = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/txip_seq.sv
module txip_seq
  import txip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_ready,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] fifo_head,
  input  logic              crc_arm,
  input  logic              eom_clear,
  output logic              pop,
  output logic              close_evt,
  output logic              in_crc,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data
);
  tx_src_e           src;
  logic [15:0]       crc_acc;
  logic [7:0]        crc_lo;
  logic              in_frame, crc_on, eom_done;
  logic              hs;

  assign hs        = out_valid && out_ready;
  assign pop       = hs && (src == SRC_NORM) && !fifo_empty;
  assign close_evt = hs && (src == SRC_CLOSE);
  assign in_crc    = (src != SRC_NORM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= IDLE_CHR;
      out_valid <= 1'b0;
      src       <= SRC_NORM;
      crc_acc   <= CRC_SEED;
      crc_lo    <= '0;
      in_frame  <= 1'b0;
      crc_on    <= 1'b0;
      eom_done  <= 1'b1;
    end else begin
      out_valid <= 1'b1;
      if (crc_arm)   crc_on   <= 1'b1;
      if (eom_clear) eom_done <= 1'b0;
      if (hs) begin
        case (src)
          SRC_NORM: begin
            if (!fifo_empty) begin
              out_data <= fifo_head;
              crc_acc  <= crc_step(in_frame ? crc_acc : CRC_SEED, fifo_head);
              in_frame <= 1'b1;
            end else if (in_frame) begin
              in_frame <= 1'b0;
              eom_done <= 1'b1;
              if (!eom_done && crc_on) begin
                out_data <= crc_acc[15:8];
                crc_lo   <= crc_acc[7:0];
                crc_on   <= 1'b0;
                src      <= SRC_CRC_LO;
              end else begin
                out_data <= IDLE_CHR;
              end
            end else begin
              out_data <= IDLE_CHR;
            end
          end
          SRC_CRC_LO: begin
            out_data <= crc_lo;
            src      <= SRC_CLOSE;
          end
          default: begin
            out_data <= IDLE_CHR;
            src      <= SRC_NORM;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/txip_irq.sv
module txip_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_ie,
  input  logic drain_mode,
  input  logic pop,
  input  logic drained,
  input  logic wr_accept,
  input  logic ip_clear,
  input  logic close_evt,
  output logic txip
);
  logic data_ip, eof_ip;
  logic retire, data_set, eof_set;

  assign retire   = wr_accept || ip_clear;
  assign data_set = tx_ie && pop && (!drain_mode || drained);
  assign eof_set  = tx_ie && close_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_ip <= 1'b0;
      eof_ip  <= 1'b0;
    end else begin
      if (data_set)                data_ip <= 1'b1;
      else if (retire && data_ip)  data_ip <= 1'b0;
      if (eof_set)                 eof_ip  <= 1'b1;
      else if (retire && !data_ip) eof_ip  <= 1'b0;
    end
  end

  assign txip = data_ip || eof_ip;
endmodule

// File: rtl/txip_ctrl.sv
module txip_ctrl
  import txip_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_ie,
  input  logic              drain_mode,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ip_clear,
  input  logic              crc_arm,
  input  logic              eom_clear,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              txip,
  output logic              buf_empty,
  output logic              overflow
);
  localparam int CW = $clog2(DEPTH + 1);

  logic              push, full, empty, seq_pop, drained, close_evt, seq_in_crc;
  logic [BYTE_W-1:0] head;
  logic [CW-1:0]     count;

  assign push     = wr_valid && !full;
  assign wr_ready = !full;
  assign drained  = seq_pop && (count == CW'(1)) && !push;
  assign buf_empty = empty;

  txip_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(wr_data), .pop(seq_pop),
    .head(head), .count(count), .full(full), .empty(empty)
  );

  txip_seq u_seq (
    .clk(clk), .rst_n(rst_n), .out_ready(out_ready), .fifo_empty(empty),
    .fifo_head(head), .crc_arm(crc_arm), .eom_clear(eom_clear), .pop(seq_pop),
    .close_evt(close_evt), .in_crc(seq_in_crc), .out_valid(out_valid),
    .out_data(out_data)
  );

  txip_irq u_irq (
    .clk(clk), .rst_n(rst_n), .tx_ie(tx_ie), .drain_mode(drain_mode),
    .pop(seq_pop), .drained(drained), .wr_accept(push), .ip_clear(ip_clear),
    .close_evt(close_evt), .txip(txip)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                     overflow <= 1'b0;
    else if (wr_valid && full)      overflow <= 1'b1;
  end
endmodule

// File: rtl/txip_checker.sv
module txip_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic overflow,
  input logic tx_ie,
  input logic txip,
  input logic out_valid,
  input logic buf_empty,
  input logic in_crc,
  input logic pop
);
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_drop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> overflow);
  assert_no_ip_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ie && !txip) |=> !txip);
  assert_crc_holds_fifo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_crc |-> !pop);
  assert_write_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !buf_empty);
  assert_stream_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);
endmodule

bind txip_ctrl txip_checker i_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .overflow(overflow), .tx_ie(tx_ie), .txip(txip), .out_valid(out_valid),
  .buf_empty(buf_empty), .in_crc(seq_in_crc), .pop(seq_pop)
);

// File: tb/test_txip_ctrl.sv
`timescale 1ns/1ps
module test_txip_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_ie = 1'b0, drain_mode = 1'b1;
  logic       wr_valid = 1'b0, ip_clear = 1'b0, crc_arm = 1'b0, eom_clear = 1'b0;
  logic       out_ready = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, out_valid, txip, buf_empty, overflow;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [7:0]  exp_q [$];
  logic [15:0] bcrc;

  always #2 clk = ~clk;

  txip_ctrl i_txip_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_ie(tx_ie), .drain_mode(drain_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .ip_clear(ip_clear), .crc_arm(crc_arm), .eom_clear(eom_clear),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .txip(txip), .buf_empty(buf_empty), .overflow(overflow)
  );

  function automatic logic [15:0] ref_crc(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    c = c_in ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    return c;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: byte handed over at the next posedge
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() > 0 && out_data == exp_q[0]) begin
        void'(exp_q.pop_front());
        checks++;
      end else if (out_data != 8'h7E) begin
        checks++;
        errors++;
        $display("FAIL R5/R11 stream: actual %h expected %h", out_data,
                 (exp_q.size() > 0) ? exp_q[0] : 8'h7E);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      out_ready = 1'b1;
      tick();
      out_ready = 1'b0;
    end
  endtask

  task automatic new_frame();
    bcrc = 16'hFFFF;
  endtask

  // Driver: writes a byte and queues it as expected when it should be accepted
  task automatic put(input logic [7:0] b, input bit accept);
    wr_data  = b;
    wr_valid = 1'b1;
    tick();
    wr_valid = 1'b0;
    if (accept) begin
      exp_q.push_back(b);
      bcrc = ref_crc(bcrc, b);
    end
  endtask

  task automatic push_crc();
    exp_q.push_back(bcrc[15:8]);
    exp_q.push_back(bcrc[7:0]);
  endtask

  task automatic pulse_clear();
    ip_clear = 1'b1; tick(); ip_clear = 1'b0;
  endtask

  task automatic pulse_frame_cmds(input bit arm, input bit eom);
    crc_arm = arm; eom_clear = eom; tick();
    crc_arm = 1'b0; eom_clear = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R10 reset state
    chk("R10 txip", txip, 0);
    chk("R10 overflow", overflow, 0);
    chk("R10 buf_empty", buf_empty, 1);
    chk("R10 out_valid", out_valid, 1);
    chk("R10 out_data", out_data, 8'h7E);
    chk("R9 wr_ready", wr_ready, 1);

    // R2: enabling with empty FIFO sets nothing
    tx_ie = 1'b1; drain_mode = 1'b1;
    step(4);
    chk("R2 enable alone", txip, 0);

    // R1/R4/R6/R11: drain-mode frame with CRC
    new_frame();
    put(8'hA1, 1); put(8'hA2, 1); put(8'h3C, 1);
    chk("R8 not empty", buf_empty, 0);
    chk("R1 no ip yet", txip, 0);
    pulse_frame_cmds(1, 1);
    push_crc();
    step(1); chk("R1 drain 1", txip, 0);
    step(1); chk("R1 drain 2", txip, 0);
    step(1); chk("R1 drained", txip, 1);
    chk("R8 empty", buf_empty, 1);
    step(3);
    chk("R4 eof pending", txip, 1);
    pulse_clear(); chk("R6 one clear", txip, 1);
    pulse_clear(); chk("R6 two clears", txip, 0);

    // R7: no eom_clear -> no CRC, no eof level
    new_frame();
    put(8'hD1, 1); put(8'hD2, 1);
    pulse_frame_cmds(1, 0);
    step(2); chk("R7 data ip", txip, 1);
    step(1);
    pulse_clear(); chk("R7 single clear", txip, 0);
    step(3); chk("R7 no eof", txip, 0);

    // R5: write during CRC waits; write retires data level (R3)
    new_frame();
    put(8'hB1, 1); put(8'hB2, 1);
    pulse_frame_cmds(1, 1);
    push_crc();
    step(2); chk("R1 frame B drained", txip, 1);
    step(1);                       // CRC high byte loaded
    new_frame();
    put(8'hC1, 1);
    chk("R3 write retires", txip, 0);
    step(1); chk("R5 crc lo held", buf_empty, 0);
    step(1); chk("R4 closing flag eof", txip, 1);
    step(1);                       // C1 leaves
    chk("R5 C1 after crc", buf_empty, 1);
    pulse_clear(); chk("R6 both levels", txip, 1);
    pulse_clear(); chk("R6 cleared", txip, 0);
    step(1);

    // R1 mode 0 and R3 retire by write/command
    drain_mode = 1'b0;
    new_frame();
    put(8'hE1, 1); put(8'hE2, 1); put(8'hE3, 1);
    step(1); chk("R1 room ip", txip, 1);
    put(8'hE4, 1); chk("R3 write clear", txip, 0);
    step(1); chk("R1 room ip again", txip, 1);
    pulse_clear(); chk("R3 command clear", txip, 0);
    step(3);
    pulse_clear(); chk("R3 idle", txip, 0);

    // R9 overflow
    drain_mode = 1'b1;
    new_frame();
    put(8'hF1, 1); put(8'hF2, 1); put(8'hF3, 1); put(8'hF4, 1);
    chk("R9 full ready", wr_ready, 0);
    chk("R9 no ovf yet", overflow, 0);
    put(8'hF5, 0);
    chk("R9 ovf set", overflow, 1);
    step(6);
    chk("R9 ovf sticky", overflow, 1);
    chk("R9 ready back", wr_ready, 1);
    pulse_clear();

    // R8/R2 with interrupts disabled
    tx_ie = 1'b0;
    new_frame();
    put(8'h11, 1);
    chk("R8 poll full", buf_empty, 0);
    step(1);
    chk("R8 poll drained", buf_empty, 1);
    chk("R2 disabled", txip, 0);
    step(1);
    tx_ie = 1'b1;
    step(3);
    chk("R2 re-enable", txip, 0);

    chk("R5 queue drained", 16'(exp_q.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule